// File: doc/BRIEF.md
# Processor Status Flag Register

This block is the status register of a small 8-bit processor core. It holds three arithmetic flags (zero, digit carry, carry) and two reset-cause bits (time-out and power-down). Each cycle it combines three sources into the next register value: flag results from the ALU, an ordinary register write from the datapath, and event strobes from the watchdog and power controller.

The ALU supplies finished flag values and, for each flag, an enable that marks whether the current instruction affects that flag. The carry and digit-carry values are stored exactly as they are supplied. For subtraction the ALU adds the two's complement of the second operand, so a stored carry of 1 means that no borrow occurred. Digit carry is the carry out of bit 3, and carry is the carry out of the top bit.

An instruction that targets this register and also affects flags cannot use its data to overwrite the arithmetic bits. The flag logic decides them. So a clear of the register, which forces the zero flag, leaves the register with Z set, the upper bits at zero and every other bit unchanged. The reset-cause bits change only through events.

Top module: `stat_reg`

## Requirements
- R1: Bit 4 is time-out (TO), bit 3 is power-down (PD), bit 2 is zero (Z), bit 1 is digit carry (DC) and bit 0 is carry (C). Bits above bit 4 always read 0.
- R2: While `rst_n` is low the register reads 0x18: TO and PD are 1 and Z, DC and C are 0.
- R3: A write (`wr_en`=1) with all of `flag_en` at 0 loads bits 2:0 from `wr_data[2:0]` on the next edge.
- R4: A write with any `flag_en` bit set ignores `wr_data` for bits 2:0. Each enabled flag takes its `flag_val` bit and each disabled flag keeps its value. Index 0 is C, 1 is DC and 2 is Z.
- R5: Without a write, each enabled flag takes its `flag_val` bit and each other flag holds its value.
- R6: Writes never change TO, PD or the bits above bit 4.
- R7: TO is cleared by `wdt_tmo`. Otherwise it is set by `wdt_clr` or `sleep_ent`. `wdt_tmo` wins over both of these when they occur in the same cycle.
- R8: PD is cleared by `sleep_ent`. Otherwise it is set by `wdt_clr`. `sleep_ent` wins over `wdt_clr` in the same cycle.
- R9: `pwr_up` sets both TO and PD, and it wins over every other event.
- R10: With no write, no flag enable and no event, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | REG_W | Write data |
| flag_val | input | 3 | ALU flag results {Z, DC, C} |
| flag_en | input | 3 | Per-flag update enables {Z, DC, C} |
| wdt_clr | input | 1 | Watchdog clear event |
| sleep_ent | input | 1 | Sleep entry event |
| wdt_tmo | input | 1 | Watchdog timeout event |
| pwr_up | input | 1 | Power-up event |
| status_q | output | REG_W | Register value |

## Verification
The bench builds the block with its default width of 8 bits. At that width the three unimplemented top bits can be driven through `wr_data`, so the check that they read zero is a real one. The random mix is weighted so that a write often coincides with flag enables and two or three events often land in the same cycle. This exercises every case where one source overrides another.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int C_BIT   = 0;
  localparam int DC_BIT  = 1;
  localparam int Z_BIT   = 2;
  localparam int PD_BIT  = 3;
  localparam int TO_BIT  = 4;
  localparam int ARITH_N = 3;
  localparam int USED_N  = 5;

  // Next value of one arithmetic flag bit.
  function automatic logic arith_next(logic cur, logic en, logic val,
                                      logic wr, logic dbit, logic any_en);
    if (en)               return val;
    else if (wr && !any_en) return dbit;
    else                  return cur;
  endfunction

  // Time-out: power-up > timeout clear > clear/sleep set.
  function automatic logic to_next(logic cur, logic pu, logic tmo,
                                   logic clr, logic slp);
    if (pu)              return 1'b1;
    else if (tmo)        return 1'b0;
    else if (clr || slp) return 1'b1;
    else                 return cur;
  endfunction

  // Power-down: power-up > sleep clear > watchdog clear set.
  function automatic logic pd_next(logic cur, logic pu, logic slp, logic clr);
    if (pu)       return 1'b1;
    else if (slp) return 1'b0;
    else if (clr) return 1'b1;
    else          return cur;
  endfunction
endpackage

// File: rtl/arith_flags.sv
module arith_flags
  import stat_pkg::*;
#(
  parameter int N = ARITH_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [N-1:0] wr_bits,
  input  logic [N-1:0] flag_val,
  input  logic [N-1:0] flag_en,
  output logic [N-1:0] q
);
  logic any_en;
  assign any_en = |flag_en;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic nxt;
    assign nxt = arith_next(q[i], flag_en[i], flag_val[i], wr_en, wr_bits[i], any_en);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= nxt;
    end
  end
endmodule

// File: rtl/cause_bits.sv
module cause_bits
  import stat_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wdt_clr,
  input  logic sleep_ent,
  input  logic wdt_tmo,
  input  logic pwr_up,
  output logic to_q,
  output logic pd_q
);
  logic to_d, pd_d;
  assign to_d = to_next(to_q, pwr_up, wdt_tmo, wdt_clr, sleep_ent);
  assign pd_d = pd_next(pd_q, pwr_up, sleep_ent, wdt_clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_q <= 1'b1;
      pd_q <= 1'b1;
    end else begin
      to_q <= to_d;
      pd_q <= pd_d;
    end
  end
endmodule

// File: rtl/stat_reg.sv
module stat_reg
  import stat_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic [2:0]       flag_val,
  input  logic [2:0]       flag_en,
  input  logic             wdt_clr,
  input  logic             sleep_ent,
  input  logic             wdt_tmo,
  input  logic             pwr_up,
  output logic [REG_W-1:0] status_q
);
  localparam int PAD_W = REG_W - USED_N;

  logic [ARITH_N-1:0] arith_q;
  logic               to_q, pd_q;
  logic               unused_wr_hi;

  assign unused_wr_hi = ^wr_data[REG_W-1:ARITH_N];

  arith_flags #(.N(ARITH_N)) u_arith (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_bits  (wr_data[ARITH_N-1:0]),
    .flag_val (flag_val),
    .flag_en  (flag_en),
    .q        (arith_q)
  );

  cause_bits u_cause (
    .clk       (clk),
    .rst_n     (rst_n),
    .wdt_clr   (wdt_clr),
    .sleep_ent (sleep_ent),
    .wdt_tmo   (wdt_tmo),
    .pwr_up    (pwr_up),
    .to_q      (to_q),
    .pd_q      (pd_q)
  );

  assign status_q[ARITH_N-1:0] = arith_q;
  assign status_q[PD_BIT]      = pd_q;
  assign status_q[TO_BIT]      = to_q;

  if (PAD_W > 0) begin : g_pad
    assign status_q[REG_W-1:USED_N] = '0;
  end
endmodule

// File: rtl/stat_reg_chk.sv
module stat_reg_chk #(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [2:0]       wr_low,
  input logic [2:0]       flag_val,
  input logic [2:0]       flag_en,
  input logic             wdt_clr,
  input logic             sleep_ent,
  input logic             wdt_tmo,
  input logic             pwr_up,
  input logic [REG_W-1:0] status_q
);
  p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[REG_W-1:5] == '0);

  p_plain_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && flag_en == 3'b000) |=> status_q[2:0] == $past(wr_low));

  p_flags_win_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && flag_en != 3'b000) |=>
      status_q[2:0] == (($past(flag_en) & $past(flag_val)) |
                        (~$past(flag_en) & $past(status_q[2:0]))));

  p_cause_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wdt_clr && !sleep_ent && !wdt_tmo && !pwr_up) |=> $stable(status_q[4:3]));

  p_tmo_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_tmo && !pwr_up) |=> !status_q[4]);

  p_sleep_pd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_ent && !pwr_up) |=> !status_q[3]);

  p_pwrup_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_up |=> status_q[4:3] == 2'b11);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && flag_en == 3'b000 && !wdt_clr && !sleep_ent && !wdt_tmo && !pwr_up)
      |=> $stable(status_q));
endmodule

bind stat_reg stat_reg_chk #(.REG_W(REG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_low    (wr_data[2:0]),
  .flag_val  (flag_val),
  .flag_en   (flag_en),
  .wdt_clr   (wdt_clr),
  .sleep_ent (sleep_ent),
  .wdt_tmo   (wdt_tmo),
  .pwr_up    (pwr_up),
  .status_q  (status_q)
);

// File: tb/sim_stat_reg.sv
`timescale 1ns/1ps
module sim_stat_reg;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [2:0]   flag_val = '0;
  logic [2:0]   flag_en = '0;
  logic         wdt_clr = 1'b0, sleep_ent = 1'b0, wdt_tmo = 1'b0, pwr_up = 1'b0;
  logic [W-1:0] status_q;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] model;

  always #2.5 clk = ~clk;

  stat_reg #(.REG_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .flag_val(flag_val), .flag_en(flag_en), .wdt_clr(wdt_clr),
    .sleep_ent(sleep_ent), .wdt_tmo(wdt_tmo), .pwr_up(pwr_up),
    .status_q(status_q)
  );

  // Independent restatement of the requirements as byte operations.
  function automatic logic [7:0] expect_next(logic [7:0] s, logic we, logic [7:0] d,
      logic [2:0] fv, logic [2:0] fe, logic clr, logic slp, logic tmo, logic pu);
    logic [7:0] r;
    logic [2:0] keep;
    r = s & 8'h1F;
    if (fe != 3'b000) r[2:0] = (fv & fe) | (s[2:0] & ~fe);   // R4, R5
    else if (we)      r[2:0] = d[2:0];                        // R3
    keep = 3'b000;
    if (tmo)              r[4] = 1'b0;                        // R7
    else if (clr | slp)   r[4] = 1'b1;
    if (slp)              r[3] = 1'b0;                        // R8
    else if (clr)         r[3] = 1'b1;
    if (pu) r[4:3] = 2'b11;                                   // R9
    return r | {5'b0, keep};
  endfunction

  function automatic string tag_of(logic we, logic [2:0] fe, logic clr,
                                   logic slp, logic tmo, logic pu);
    if (pu)                 return "R9";
    if (tmo)                return "R7";
    if (slp || clr)         return "R8";
    if (we && fe != 3'b000) return "R4";
    if (we)                 return "R3";
    if (fe != 3'b000)       return "R5";
    return "R10";
  endfunction

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  // Drive one cycle at the falling edge, then compare just after the rising edge.
  task automatic step(logic we, logic [7:0] d, logic [2:0] fv, logic [2:0] fe,
                      logic clr, logic slp, logic tmo, logic pu, string req);
    logic [7:0] exp;
    @(negedge clk);
    wr_en = we; wr_data = d; flag_val = fv; flag_en = fe;
    wdt_clr = clr; sleep_ent = slp; wdt_tmo = tmo; pwr_up = pu;
    exp = expect_next(model, we, d, fv, fe, clr, slp, tmo, pu);
    @(posedge clk); #1;
    check(req, status_q, exp);
    model = exp;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired got=hang exp=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    #1;
    check("R2", status_q, 8'h18);
    @(negedge clk); rst_n = 1'b1;
    model = 8'h18;

    // R1 and R6: write all ones with no flags; only bits 2:0 change.
    step(1, 8'hFF, 3'b000, 3'b000, 0, 0, 0, 0, "R1");
    // R6: write zeros leaves TO and PD at 1.
    step(1, 8'h00, 3'b000, 3'b000, 0, 0, 0, 0, "R6");
    // R3: plain write pattern.
    step(1, 8'hE5, 3'b000, 3'b000, 0, 0, 0, 0, "R3");
    // R4: clear-style write: data 0, only Z affected and set; DC, C kept.
    step(1, 8'h00, 3'b100, 3'b100, 0, 0, 0, 0, "R4");
    // R5: update C alone.
    step(0, 8'hFF, 3'b110, 3'b001, 0, 0, 0, 0, "R5");
    // R7: timeout with clear and sleep in the same cycle.
    step(0, 8'h00, 3'b000, 3'b000, 1, 1, 1, 0, "R7");
    // R8: sleep and clear together.
    step(0, 8'h00, 3'b000, 3'b000, 1, 1, 0, 0, "R8");
    // R9: power-up against everything.
    step(1, 8'h00, 3'b000, 3'b000, 1, 1, 1, 1, "R9");
    // R10: idle hold.
    step(0, 8'hAA, 3'b111, 3'b000, 0, 0, 0, 0, "R10");

    for (int i = 0; i < 4000; i++) begin
      logic we, clr, slp, tmo, pu;
      logic [2:0] fe, fv;
      logic [7:0] d;
      we  = ($urandom % 2) == 0;
      d   = 8'($urandom);
      fv  = 3'($urandom);
      fe  = (($urandom % 2) == 0) ? 3'b000 : 3'($urandom);
      clr = ($urandom % 4) == 0;
      slp = ($urandom % 4) == 0;
      tmo = ($urandom % 5) == 0;
      pu  = ($urandom % 9) == 0;
      step(we, d, fv, fe, clr, slp, tmo, pu, tag_of(we, fe, clr, slp, tmo, pu));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule